// File: doc/BRIEF.md
# Dual-Port Interrupt-on-Change Controller

This block watches two 8-bit input ports that have already been synchronized to the core clock. It raises one interrupt per port when an enabled pin differs from its reference. Each pin takes one of two references, chosen by its own mode bit: the level the pin had on the previous clock, or a programmed default bit. When a port's interrupt fires, the block records which pins caused it in a flag register and takes a snapshot of the whole port in a capture register. Both are then held until software reads the port's capture or live-level register. That read clears the port's pending interrupt.

A shared configuration register sets how the two interrupt outputs are driven. In mirror mode the two port interrupts are ORed, so both outputs follow the combined event. In push-pull mode a polarity bit selects active-low or active-high. In open-drain mode the data output is held low and its output enable is asserted only while the interrupt is active, and the polarity bit has no effect. Registers are reached through a simple strobe interface: a write strobe, a read strobe, a 4-bit select and 8-bit data, with combinational read data.

Top module: `ioc_irq_ctrl`

## Requirements
- R1: After reset, every register (enable, mode, default, flag, capture, configuration) reads 0x00. Both interrupt outputs are idle, which at reset means level 1 with the output enable at 1.
- R2: A pin whose enable bit is 0 never sets its flag, whatever its level does.
- R3: An enabled pin with mode bit 0 flags when its sampled level differs from its level one clock earlier.
- R4: An enabled pin with mode bit 1 flags when its level differs from the matching bit of the default register.
- R5: When a port with no pending interrupt sees one or more events at a clock edge, that edge loads the flag register with exactly the pins that triggered. The same edge loads the capture register with the port level sampled at that edge. The port interrupt is active from then on.
- R6: While a port has a pending interrupt, its flag and capture registers do not change, unless a clear occurs.
- R7: A read strobe with the capture field (select[3:1]=4) or the level field (select[3:1]=5) of a port clears that port's flags at the next edge. In default-compare mode, a mismatch that persists raises the interrupt again on the following edge.
- R8: With config bit 0 (mirror) set, each output is driven by the OR of both port interrupts. With it clear, each output follows its own port.
- R9: With open-drain off, an active output drives the level of config bit 1 (0 = active-low, 1 = active-high), an idle output drives its inverse, and the output enable is 1.
- R10: With config bit 2 (open-drain) set, the data output is 0 and the output enable equals the interrupt state, regardless of bit 1.
- R11: The register select is {field[2:0], port}, with port 0 = A and port 1 = B. The fields are: 0 enable, 1 mode, 2 default, 3 flags, 4 capture, 5 live level, 6 configuration (shared; either port bit). Fields 0, 1, 2 and 6 are writable and read back what was written. Read data is combinational from the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 8 | Synchronized levels of port A |
| pin_b | input | 8 | Synchronized levels of port B |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: clear) |
| reg_sel | input | 4 | Register select {field, port} |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| irq_a_o | output | 1 | Interrupt A data output |
| irq_a_oe | output | 1 | Interrupt A output enable |
| irq_b_o | output | 1 | Interrupt B data output |
| irq_b_oe | output | 1 | Interrupt B output enable |

## Verification
The assertions assume that the pin vectors are already synchronous to clk, and that a read and a write are never strobed together. They also assume that a clear is a single-cycle read strobe, so the capture check after a rising interrupt is never masked by an overlapping clear. The random stimulus flips pins with a low probability and issues at most one register access per cycle, so pending, frozen and cleared phases all occur many times. Directed sequences reach the cases that random traffic rarely hits: a clear that meets a persisting default mismatch, an edge on a disabled pin, and each output-drive mode.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
    typedef enum logic [2:0] {
        F_EN   = 3'd0,
        F_MODE = 3'd1,
        F_DEF  = 3'd2,
        F_FLAG = 3'd3,
        F_CAP  = 3'd4,
        F_LVL  = 3'd5,
        F_CFG  = 3'd6
    } field_e;

    typedef struct packed {
        logic od;      // open-drain drive
        logic pol;     // active level in push-pull drive
        logic mirror;  // OR both port interrupts
    } cfg_t;
endpackage

// File: rtl/ioc_port.sv
module ioc_port
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         wr_i,
    input  field_e       field_i,
    input  logic [W-1:0] wdata_i,
    input  logic         clr_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] mode_o,
    output logic [W-1:0] def_o,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] cap_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] mode;
        logic [W-1:0] dflt;
        logic [W-1:0] flag;
        logic [W-1:0] cap;
        logic [W-1:0] prev;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] hit;
    logic         pend;

    always_comb begin
        st_d = st_q;
        st_d.prev = pins_i;
        if (wr_i) begin
            case (field_i)
                F_EN:    st_d.en   = wdata_i;
                F_MODE:  st_d.mode = wdata_i;
                F_DEF:   st_d.dflt = wdata_i;
                default: ;
            endcase
        end
        hit  = st_q.en & ((st_q.mode & (pins_i ^ st_q.dflt)) |
                          (~st_q.mode & (pins_i ^ st_q.prev)));
        pend = |st_q.flag;
        if (clr_i) begin
            st_d.flag = '0;
        end else if (!pend && (|hit)) begin
            st_d.flag = hit;
            st_d.cap  = pins_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign mode_o = st_q.mode;
    assign def_o  = st_q.dflt;
    assign flag_o = st_q.flag;
    assign cap_o  = st_q.cap;
    assign pend_o = pend;

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !clr_i) |=> ((flag_o & ~$past(en_o)) == '0)); // R2
    AST_CAPTURE_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> (cap_o == $past(pins_i))); // R5
    AST_FROZEN_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> ($stable(flag_o) && $stable(cap_o))); // R6
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flag_o == '0)); // R7
endmodule

// File: rtl/ioc_irq_drv.sv
module ioc_irq_drv (
    input  logic act_i,
    input  logic pol_i,
    input  logic od_i,
    output logic pin_o,
    output logic oe_o
);
    always_comb begin
        if (od_i) begin
            pin_o = 1'b0;
            oe_o  = act_i;
        end else begin
            pin_o = act_i ? pol_i : ~pol_i;
            oe_o  = 1'b1;
        end
    end
endmodule

// File: rtl/ioc_irq_ctrl.sv
module ioc_irq_ctrl
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [3:0]   reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         irq_a_o,
    output logic         irq_a_oe,
    output logic         irq_b_o,
    output logic         irq_b_oe
);
    localparam int NPORT = 2;
    localparam int CFG_W = $bits(cfg_t);

    cfg_t         cfg_d, cfg_q;
    field_e       field;
    logic         port;
    logic [W-1:0] pins   [NPORT];
    logic [W-1:0] en_v   [NPORT];
    logic [W-1:0] mode_v [NPORT];
    logic [W-1:0] def_v  [NPORT];
    logic [W-1:0] flag_v [NPORT];
    logic [W-1:0] cap_v  [NPORT];
    logic         pend   [NPORT];
    logic         act    [NPORT];
    logic         drv_o  [NPORT];
    logic         drv_oe [NPORT];

    assign field   = field_e'(reg_sel[3:1]);
    assign port    = reg_sel[0];
    assign pins[0] = pin_a;
    assign pins[1] = pin_b;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && field == F_CFG) cfg_d = cfg_t'(wr_data[CFG_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic sel_me;
        assign sel_me = (port == 1'(p));

        ioc_port #(.W(W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins_i  (pins[p]),
            .wr_i    (wr_en && sel_me),
            .field_i (field),
            .wdata_i (wr_data),
            .clr_i   (rd_en && sel_me && (field == F_CAP || field == F_LVL)),
            .en_o    (en_v[p]),
            .mode_o  (mode_v[p]),
            .def_o   (def_v[p]),
            .flag_o  (flag_v[p]),
            .cap_o   (cap_v[p]),
            .pend_o  (pend[p])
        );

        assign act[p] = cfg_q.mirror ? (pend[0] | pend[1]) : pend[p];

        ioc_irq_drv u_drv (
            .act_i (act[p]),
            .pol_i (cfg_q.pol),
            .od_i  (cfg_q.od),
            .pin_o (drv_o[p]),
            .oe_o  (drv_oe[p])
        );
    end

    always_comb begin
        case (field)
            F_EN:    rd_data = en_v[port];
            F_MODE:  rd_data = mode_v[port];
            F_DEF:   rd_data = def_v[port];
            F_FLAG:  rd_data = flag_v[port];
            F_CAP:   rd_data = cap_v[port];
            F_LVL:   rd_data = pins[port];
            F_CFG:   rd_data = W'(cfg_q);
            default: rd_data = '0;
        endcase
    end

    assign irq_a_o  = drv_o[0];
    assign irq_a_oe = drv_oe[0];
    assign irq_b_o  = drv_o[1];
    assign irq_b_oe = drv_oe[1];

    AST_MIRROR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.mirror |-> (irq_a_o == irq_b_o && irq_a_oe == irq_b_oe)); // R8
    AST_OD_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.od |-> (!irq_a_o && !irq_b_o)); // R10
endmodule

// File: tb/sim_ioc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ioc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_a = '0, pin_b = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_a_o, irq_a_oe, irq_b_o, irq_b_oe;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_en[2], m_mode[2], m_def[2], m_flag[2], m_cap[2], m_prev[2];
    logic [2:0] m_cfg;

    always #5 clk = ~clk;

    ioc_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel), .wr_data(wr_data),
        .rd_data(rd_data), .irq_a_o(irq_a_o), .irq_a_oe(irq_a_oe),
        .irq_b_o(irq_b_o), .irq_b_oe(irq_b_oe)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_act(input int p);
        logic pa, pb;
        pa = |m_flag[0];
        pb = |m_flag[1];
        return m_cfg[0] ? (pa | pb) : (p == 0 ? pa : pb);
    endfunction

    function automatic logic [1:0] exp_drive(input int p);   // {o, oe}
        logic a;
        a = exp_act(p);
        if (m_cfg[2]) return {1'b0, a};
        return {(a ? m_cfg[1] : ~m_cfg[1]), 1'b1};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] s);
        int p;
        p = s[0];
        case (s[3:1])
            3'd0: return m_en[p];
            3'd1: return m_mode[p];
            3'd2: return m_def[p];
            3'd3: return m_flag[p];
            3'd4: return m_cap[p];
            3'd5: return (p == 0) ? pin_a : pin_b;
            3'd6: return {5'b0, m_cfg};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_all(input string tag);
        logic [1:0] da, db;
        da = exp_drive(0);
        db = exp_drive(1);
        chk(tag, "irq_a_o",  {7'b0, irq_a_o},  {7'b0, da[1]});
        chk(tag, "irq_a_oe", {7'b0, irq_a_oe}, {7'b0, da[0]});
        chk(tag, "irq_b_o",  {7'b0, irq_b_o},  {7'b0, db[1]});
        chk(tag, "irq_b_oe", {7'b0, irq_b_oe}, {7'b0, db[0]});
        chk(tag, "rd_data",  rd_data, exp_rd(reg_sel));
    endtask

    task automatic step(input logic [7:0] pa, input logic [7:0] pb, input logic wr, input logic rd,
                        input logic [3:0] sel, input logic [7:0] wd, input string tag);
        logic [7:0] n_en[2], n_mode[2], n_def[2], n_flag[2], n_cap[2];
        logic [2:0] n_cfg;
        @(negedge clk);
        pin_a = pa; pin_b = pb; wr_en = wr; rd_en = rd; reg_sel = sel; wr_data = wd;
        n_cfg = (wr && sel[3:1] == 3'd6) ? wd[2:0] : m_cfg;
        for (int p = 0; p < 2; p++) begin
            logic [7:0] pin, hit;
            logic clr;
            pin = (p == 0) ? pa : pb;
            hit = m_en[p] & ((m_mode[p] & (pin ^ m_def[p])) | (~m_mode[p] & (pin ^ m_prev[p])));
            clr = rd && (sel[0] == p[0]) && (sel[3:1] == 3'd4 || sel[3:1] == 3'd5);
            n_en[p] = m_en[p]; n_mode[p] = m_mode[p]; n_def[p] = m_def[p];
            n_flag[p] = m_flag[p]; n_cap[p] = m_cap[p];
            if (wr && sel[0] == p[0]) begin
                if (sel[3:1] == 3'd0) n_en[p]   = wd;
                if (sel[3:1] == 3'd1) n_mode[p] = wd;
                if (sel[3:1] == 3'd2) n_def[p]  = wd;
            end
            if (clr) n_flag[p] = 8'h00;
            else if (m_flag[p] == 8'h00 && hit != 8'h00) begin
                n_flag[p] = hit;
                n_cap[p]  = pin;
            end
        end
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            m_en[p] = n_en[p]; m_mode[p] = n_mode[p]; m_def[p] = n_def[p];
            m_flag[p] = n_flag[p]; m_cap[p] = n_cap[p];
            m_prev[p] = (p == 0) ? pa : pb;
        end
        m_cfg = n_cfg;
        #2;
        check_all(tag);
    endtask

    // shorthands: idle, write, read
    task automatic idle(input string tag);
        step(pin_a, pin_b, 1'b0, 1'b0, reg_sel, 8'h00, tag);
    endtask
    task automatic wreg(input logic [2:0] f, input logic p, input logic [7:0] d, input string tag);
        step(pin_a, pin_b, 1'b1, 1'b0, {f, p}, d, tag);
    endtask
    task automatic rreg(input logic [2:0] f, input logic p, input string tag);
        step(pin_a, pin_b, 1'b0, 1'b1, {f, p}, 8'h00, tag);
    endtask
    task automatic peek(input logic [2:0] f, input logic p, input string tag);
        step(pin_a, pin_b, 1'b0, 1'b0, {f, p}, 8'h00, tag);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] ra, rb;
        int seed;
        for (int p = 0; p < 2; p++) begin
            m_en[p] = 0; m_mode[p] = 0; m_def[p] = 0; m_flag[p] = 0; m_cap[p] = 0; m_prev[p] = 0;
        end
        m_cfg = 3'b000;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state of outputs and every register
        check_all("R1");
        for (int f = 0; f < 7; f++)
            for (int p = 0; p < 2; p++) begin
                reg_sel = {f[2:0], p[0]};
                #1;
                chk("R1", "reset register", rd_data, 8'h00);
            end
        @(negedge clk);
        rst_n = 1'b1;

        // R11: writable registers read back
        wreg(3'd0, 1'b0, 8'h0F, "R11"); peek(3'd0, 1'b0, "R11");
        wreg(3'd1, 1'b0, 8'h01, "R11"); peek(3'd1, 1'b0, "R11");
        wreg(3'd2, 1'b0, 8'h01, "R11"); peek(3'd2, 1'b0, "R11");
        wreg(3'd0, 1'b1, 8'hF0, "R11"); peek(3'd0, 1'b1, "R11");
        wreg(3'd6, 1'b1, 8'h00, "R11"); peek(3'd6, 1'b0, "R11");

        // R4: pin0 of A in default mode, default 1, pin low -> mismatch
        idle("R4"); peek(3'd3, 1'b0, "R4");
        // R7: read level clears, persisting mismatch re-raises
        rreg(3'd5, 1'b0, "R7");
        peek(3'd3, 1'b0, "R7");
        step(8'h01, pin_b, 1'b0, 1'b1, {3'd4, 1'b0}, 8'h00, "R7");
        peek(3'd3, 1'b0, "R7"); idle("R7");

        // R2: disabled pin 7 toggles, no interrupt
        step(8'h81, pin_b, 1'b0, 1'b0, {3'd3, 1'b0}, 8'h00, "R2");
        step(8'h01, pin_b, 1'b0, 1'b0, {3'd3, 1'b0}, 8'h00, "R2");
        // R3 / R5: previous-compare edge on pin 2
        step(8'h05, pin_b, 1'b0, 1'b0, {3'd3, 1'b0}, 8'h00, "R3");
        peek(3'd4, 1'b0, "R5");
        // R6: another edge while pending is held off
        step(8'h0D, pin_b, 1'b0, 1'b0, {3'd3, 1'b0}, 8'h00, "R6");
        peek(3'd4, 1'b0, "R6");
        rreg(3'd4, 1'b0, "R7"); idle("R7");

        // R8: port B event with mirror off, then on
        step(pin_a, 8'h10, 1'b0, 1'b0, {3'd3, 1'b1}, 8'h00, "R8");
        idle("R8");
        wreg(3'd6, 1'b0, 8'h01, "R8"); idle("R8");
        // R9: active-high push-pull
        wreg(3'd6, 1'b0, 8'h03, "R9"); idle("R9");
        wreg(3'd6, 1'b0, 8'h02, "R9"); idle("R9");
        // R10: open-drain overrides polarity
        wreg(3'd6, 1'b0, 8'h06, "R10"); idle("R10");
        rreg(3'd5, 1'b1, "R10"); idle("R10");
        wreg(3'd6, 1'b0, 8'h04, "R10"); idle("R10");

        // random phase
        seed = 1357;
        void'($urandom(seed));
        ra = pin_a; rb = pin_b;
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [3:0] s;
            if ($urandom % 4 == 0) ra = ra ^ (8'h01 << ($urandom % 8));
            if ($urandom % 4 == 0) rb = rb ^ (8'h01 << ($urandom % 8));
            op = $urandom % 12;
            s  = 4'($urandom % 14);
            case (op)
                0: step(ra, rb, 1'b1, 1'b0, {3'($urandom % 3), s[0]}, 8'($urandom), "RND");
                1: step(ra, rb, 1'b1, 1'b0, {3'd6, s[0]}, 8'($urandom), "RND");
                2, 3: step(ra, rb, 1'b0, 1'b1, s, 8'h00, "RND");
                default: step(ra, rb, 1'b0, 1'b0, s, 8'h00, "RND");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule